// File: doc/BRIEF.md
# Page Write Buffer and Write-Cycle Sequencer

This block sits behind a serial bus engine in front of a byte-wide 512 x 8 non-volatile array. The array is split into 32 pages of 16 bytes. The bus engine hands the block one event per system clock. The events are: load address, write byte, read byte, and a stop qualified by whether it fell on the clock right after an acknowledge. The block also takes the level of the write-protect input. The block keeps a single 9-bit current address. Write and read transactions share that address, so a read that follows a write starts where the write left off.

Incoming write bytes are held in a 16-entry page buffer. The slot is picked by the low four address bits, and those four bits wrap inside the page. A qualified stop starts a timed internal write cycle, provided at least one byte is held and write protect is low. During the cycle the held bytes are copied into the array and `busy_o` stays high. Every event is ignored until the cycle ends. Any other stop throws the buffer away. Reads return the byte at the current address one clock after the request. The address then advances over the full 9 bits, wrapping from 511 to 0.

Top module: `pgw_top`

## Requirements
- R1: After reset, `busy_o` is 0 and `cnt_o` is 0, and the page buffer holds no bytes. A qualified stop with no bytes held leaves `busy_o` at 0.
- R2: A write byte event stores `wr_data_i` in the buffer slot at `cnt_o[3:0]`. It then increments `cnt_o[3:0]` modulo 16 and leaves `cnt_o[8:4]` unchanged.
- R3: A read byte event places the array byte at `cnt_o` on `rd_data_o` at the next clock edge. It then sets `cnt_o` to `cnt_o+1` modulo 512, so 511 is followed by 0.
- R4: A stop with `stop_ack_i`=1, with at least one byte held and `wp_i`=0, raises `busy_o` at that clock edge. `busy_o` then stays high for exactly `WR_CYCLES` clock cycles.
- R5: A stop with `stop_ack_i`=0 empties the buffer and leaves the array unchanged. `busy_o` stays 0.
- R6: A stop while `wp_i`=1 empties the buffer and leaves the array unchanged. `busy_o` stays 0.
- R7: A write cycle writes only the slots that received a byte. The other 15 bytes of the page keep their previous contents.
- R8: While `busy_o` is 1, every event is ignored: `cnt_o` does not change and no byte enters the buffer.
- R9: A load address event sets `cnt_o` to `addr_i`.
- R10: When more than 16 bytes are written in one transaction, a later byte replaces the earlier byte in the same slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wp_i | input | 1 | Write protect level, 1 blocks array writes |
| addr_load_i | input | 1 | Load address event |
| addr_i | input | 9 | Address for a load event |
| wr_byte_i | input | 1 | Write byte event |
| wr_data_i | input | 8 | Byte for a write event |
| rd_byte_i | input | 1 | Read byte event |
| stop_i | input | 1 | Stop event |
| stop_ack_i | input | 1 | Stop fell on the clock right after an acknowledge |
| busy_o | output | 1 | Internal write cycle running |
| cnt_o | output | 9 | Current address |
| rd_data_o | output | 8 | Byte from the last read event |

## Verification
The bench writes across the end of a page. A design that carried into the page bits would put the bytes in the next page and read back the wrong values. It refills a complete page and then commits a single byte. A design that wrote all 16 slots would clobber the 15 untouched bytes. It issues an unqualified stop, a write-protected stop and a byte-less stop. Each must leave `busy_o` low and the array unchanged, and a sloppy gate would corrupt a byte that is read back later. It measures the busy window to the cycle, injects events during that window, and checks the read wrap from 511 to 0. It also checks the overwrite order when 17 bytes are sent to one page.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef enum logic [2:0] {
    EV_NONE,
    EV_STOP,
    EV_LOAD,
    EV_WR,
    EV_RD
  } ev_e;
endpackage

// File: rtl/pgw_page_buf.sv
module pgw_page_buf #(
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8,
  localparam int PAGE_BYTES = 1 << PAGE_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  we_i,
  input  logic [PAGE_W-1:0]     widx_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic [PAGE_W-1:0]     ridx_i,
  output logic [DATA_W-1:0]     rdata_o,
  output logic [PAGE_BYTES-1:0] vld_o
);
  logic [DATA_W-1:0] data_q [PAGE_BYTES];

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic hit;
    assign hit = we_i && (widx_i == PAGE_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    vld_o[g] <= 1'b0;
      else if (clr_i) vld_o[g] <= 1'b0;
      else if (hit)   vld_o[g] <= 1'b1;
    end

    always_ff @(posedge clk_i) begin
      if (hit) data_q[g] <= wdata_i;
    end
  end

  assign rdata_o = data_q[ridx_i];
endmodule

// File: rtl/pgw_wr_seq.sv
module pgw_wr_seq #(
  parameter int WR_CYCLES = 64,
  parameter int PAGE_W    = 4,
  localparam int PAGE_BYTES = 1 << PAGE_W,
  localparam int TW = $clog2(WR_CYCLES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              walk_en_o,
  output logic [PAGE_W-1:0] walk_idx_o,
  output logic              done_o
);
  logic          busy_q;
  logic [TW-1:0] timer_q;
  logic          last;

  assign last = (timer_q == TW'(WR_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      timer_q <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q  <= 1'b1;
        timer_q <= '0;
      end
    end else if (last) begin
      busy_q  <= 1'b0;
      timer_q <= '0;
    end else begin
      timer_q <= timer_q + 1'b1;
    end
  end

  assign busy_o     = busy_q;
  assign done_o     = busy_q && last;
  // the first PAGE_BYTES cycles of the window copy one slot each
  assign walk_en_o  = busy_q && (timer_q < TW'(PAGE_BYTES));
  assign walk_idx_o = timer_q[PAGE_W-1:0];

  p_start_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  p_timer_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (timer_q < TW'(WR_CYCLES)));
endmodule

// File: rtl/pgw_mem.sv
module pgw_mem #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] arr_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) arr_q[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= arr_q[raddr_i];
  end
endmodule

// File: rtl/pgw_top.sv
module pgw_top
  import pgw_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int PAGE_W    = 4,
  parameter int DATA_W    = 8,
  parameter int WR_CYCLES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wp_i,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_byte_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_byte_i,
  input  logic              stop_i,
  input  logic              stop_ack_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] cnt_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int PN_W = ADDR_W - PAGE_W;

  ev_e                   ev;
  logic [ADDR_W-1:0]     cnt_q;
  logic [PN_W-1:0]       page_q;
  logic [PAGE_BYTES-1:0] buf_vld;
  logic [DATA_W-1:0]     buf_rdata;
  logic                  commit, discard;
  logic                  walk_en, seq_done, mem_we;
  logic [PAGE_W-1:0]     walk_idx;

  // one event per clock; stop wins, everything is dropped while busy
  always_comb begin
    ev = EV_NONE;
    if (!busy_o) begin
      if (stop_i)           ev = EV_STOP;
      else if (addr_load_i) ev = EV_LOAD;
      else if (wr_byte_i)   ev = EV_WR;
      else if (rd_byte_i)   ev = EV_RD;
    end
  end

  assign commit  = (ev == EV_STOP) && stop_ack_i && !wp_i && (|buf_vld);
  assign discard = (ev == EV_STOP) && !commit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      page_q <= '0;
    end else begin
      unique case (ev)
        EV_LOAD: cnt_q <= addr_i;
        EV_WR:   cnt_q <= {cnt_q[ADDR_W-1:PAGE_W], cnt_q[PAGE_W-1:0] + 1'b1};
        EV_RD:   cnt_q <= cnt_q + 1'b1;
        default: ;
      endcase
      if (commit) page_q <= cnt_q[ADDR_W-1:PAGE_W];
    end
  end

  assign cnt_o = cnt_q;

  pgw_page_buf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (discard || seq_done),
    .we_i    (ev == EV_WR),
    .widx_i  (cnt_q[PAGE_W-1:0]),
    .wdata_i (wr_data_i),
    .ridx_i  (walk_idx),
    .rdata_o (buf_rdata),
    .vld_o   (buf_vld)
  );

  pgw_wr_seq #(.WR_CYCLES(WR_CYCLES), .PAGE_W(PAGE_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (commit),
    .busy_o     (busy_o),
    .walk_en_o  (walk_en),
    .walk_idx_o (walk_idx),
    .done_o     (seq_done)
  );

  assign mem_we = walk_en && buf_vld[walk_idx];

  pgw_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .waddr_i ({page_q, walk_idx}),
    .wdata_i (buf_rdata),
    .re_i    (ev == EV_RD),
    .raddr_i (cnt_q),
    .rdata_o (rd_data_o)
  );

  p_busy_ignore_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(cnt_o));
  p_wr_in_page_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev == EV_WR) |=> (cnt_o[ADDR_W-1:PAGE_W] == $past(cnt_o[ADDR_W-1:PAGE_W])));
  p_rd_advance_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev == EV_RD) |=> (cnt_o == $past(cnt_o) + 1'b1));
  p_discard_empty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    discard |=> (buf_vld == '0));
  p_wp_no_cycle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ev == EV_STOP) && wp_i) |=> !busy_o);
  p_mem_we_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> busy_o);
endmodule

// File: tb/pgw_top_bench.sv
module pgw_top_bench;
  localparam int WR = 24;
  localparam logic [2:0] OP_LOAD = 3'd0, OP_WR = 3'd1, OP_RD = 3'd2,
                         OP_STOPA = 3'd3, OP_STOPN = 3'd4;
  localparam int NV = 15;
  // {op, arg, expected cnt, expected read byte}
  localparam logic [28:0] VEC [NV] = '{
    {OP_LOAD,  9'h01E, 9'h01E, 8'h00},
    {OP_WR,    9'h0A1, 9'h01F, 8'h00},
    {OP_WR,    9'h0B2, 9'h010, 8'h00},
    {OP_WR,    9'h0C3, 9'h011, 8'h00},
    {OP_STOPA, 9'h000, 9'h011, 8'h00},
    {OP_LOAD,  9'h01E, 9'h01E, 8'h00},
    {OP_RD,    9'h000, 9'h01F, 8'hA1},
    {OP_RD,    9'h000, 9'h020, 8'hB2},
    {OP_LOAD,  9'h010, 9'h010, 8'h00},
    {OP_RD,    9'h000, 9'h011, 8'hC3},
    {OP_LOAD,  9'h010, 9'h010, 8'h00},
    {OP_WR,    9'h055, 9'h011, 8'h00},
    {OP_STOPN, 9'h000, 9'h011, 8'h00},
    {OP_LOAD,  9'h010, 9'h010, 8'h00},
    {OP_RD,    9'h000, 9'h011, 8'hC3}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic wp = 1'b0, ld = 1'b0, wrb = 1'b0, rdb = 1'b0, stp = 1'b0, sack = 1'b0;
  logic [8:0] addr = '0;
  logic [7:0] wdat = '0;
  logic busy;
  logic [8:0] cnt;
  logic [7:0] rdat;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pgw_top #(.WR_CYCLES(WR)) u_pgw_top (
    .clk_i(clk), .rst_ni(rst_n), .wp_i(wp), .addr_load_i(ld), .addr_i(addr),
    .wr_byte_i(wrb), .wr_data_i(wdat), .rd_byte_i(rdb), .stop_i(stp),
    .stop_ack_i(sack), .busy_o(busy), .cnt_o(cnt), .rd_data_o(rdat)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic op(input logic [2:0] o, input logic [8:0] a);
    case (o)
      OP_LOAD:  begin ld = 1'b1; addr = a; end
      OP_WR:    begin wrb = 1'b1; wdat = a[7:0]; end
      OP_RD:    rdb = 1'b1;
      OP_STOPA: begin stp = 1'b1; sack = 1'b1; end
      default:  stp = 1'b1;
    endcase
    tick();
    ld = 1'b0; wrb = 1'b0; rdb = 1'b0; stp = 1'b0; sack = 1'b0;
  endtask

  task automatic settle();
    repeat (WR + 2) tick();
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R1 busy after reset", {8'h0, busy}, 9'h0);
    chk("R1 cnt after reset", cnt, 9'h000);
    op(OP_STOPA, 9'h0);
    chk("R1 empty buffer stop no busy", {8'h0, busy}, 9'h0);

    for (int i = 0; i < NV; i++) begin
      op(VEC[i][28:26], VEC[i][25:17]);
      case (VEC[i][28:26])
        OP_LOAD:  chk("R9 load cnt", cnt, VEC[i][16:8]);
        OP_WR:    chk("R2 write cnt", cnt, VEC[i][16:8]);
        OP_RD: begin
          chk("R3 read data", {1'b0, rdat}, {1'b0, VEC[i][7:0]});
          chk("R3 read cnt", cnt, VEC[i][16:8]);
        end
        OP_STOPA: begin
          chk("R4 busy at commit", {8'h0, busy}, 9'h1);
          settle();
        end
        default: chk("R5 no busy on late stop", {8'h0, busy}, 9'h0);
      endcase
    end

    // R4 window length and R8 ignore while busy
    op(OP_LOAD, 9'h020);
    for (int i = 0; i < 16; i++) op(OP_WR, 9'(8'h40 + i));
    op(OP_STOPA, 9'h0);
    chk("R4 busy rises", {8'h0, busy}, 9'h1);
    op(OP_LOAD, 9'h100);
    op(OP_WR, 9'h0DD);
    chk("R8 cnt frozen while busy", cnt, 9'h020);
    repeat (WR - 3) tick();
    chk("R4 busy last cycle", {8'h0, busy}, 9'h1);
    tick();
    chk("R4 busy falls", {8'h0, busy}, 9'h0);
    settle();

    // R7 single byte into a full page
    op(OP_LOAD, 9'h025);
    op(OP_WR, 9'h0EE);
    op(OP_STOPA, 9'h0);
    settle();
    op(OP_LOAD, 9'h020);
    for (int i = 0; i < 16; i++) begin
      op(OP_RD, 9'h0);
      chk("R7 untouched bytes kept", {1'b0, rdat},
          (i == 5) ? 9'h0EE : 9'(8'h40 + i));
    end
    chk("R3 cnt crosses page on read", cnt, 9'h030);

    // R6 write protect
    op(OP_LOAD, 9'h020);
    op(OP_WR, 9'h099);
    wp = 1'b1;
    op(OP_STOPA, 9'h0);
    chk("R6 no busy when protected", {8'h0, busy}, 9'h0);
    wp = 1'b0;
    op(OP_STOPA, 9'h0);
    chk("R6 buffer emptied", {8'h0, busy}, 9'h0);
    op(OP_LOAD, 9'h020);
    op(OP_RD, 9'h0);
    chk("R6 array unchanged", {1'b0, rdat}, 9'h040);

    // R10 17 bytes into one page
    op(OP_LOAD, 9'h030);
    for (int i = 0; i < 17; i++) op(OP_WR, 9'(8'h80 + i));
    chk("R10 cnt after 17 bytes", cnt, 9'h031);
    op(OP_STOPA, 9'h0);
    settle();
    op(OP_LOAD, 9'h030);
    op(OP_RD, 9'h0);
    chk("R10 later byte wins", {1'b0, rdat}, 9'h090);
    op(OP_RD, 9'h0);
    chk("R10 next slot", {1'b0, rdat}, 9'h081);

    // R2 page wrap at top, R3 rollover to zero
    op(OP_LOAD, 9'h1FF);
    op(OP_WR, 9'h077);
    chk("R2 wrap in last page", cnt, 9'h1F0);
    op(OP_STOPA, 9'h0);
    settle();
    op(OP_LOAD, 9'h1FF);
    op(OP_RD, 9'h0);
    chk("R3 read top byte", {1'b0, rdat}, 9'h077);
    chk("R3 rollover to zero", cnt, 9'h000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R1 act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule